// File: doc/BRIEF.md
# Ring Node Echo-Retry Interface

This block attaches one node to a one-way packet ring on which every request is answered by an echo. Each flit is 18 bits and moves one hop per clock through a single register stage inside the block. Flits for other nodes pass through untouched.

A request for this node is taken into a small input buffer when the buffer has room, and a positive echo replaces it on the ring. When the buffer is full, a negative echo replaces it instead. Local packets from the transmit handshake go into one of four outstanding slots. A slot keeps its copy until an echo with the same tag returns to this node. A positive echo frees the slot. A negative echo queues the packet to be sent again. Local packets use only ring slots that arrive empty, so through traffic always has priority. A per-slot count of refusals raises a sticky error flag when it reaches a limit.

Top module: `ring_echo_node`

## Requirements
- R1: After reset, ring_o is idle (kind 00), tx_ready_o is 1, rx_valid_o is 0 and err_o is 0.
- R2: Flit layout: [17:16] kind (00 idle, 01 request, 10 positive echo, 11 negative echo), [15:12] target, [11:8] source, [7:6] tag, [5:0] payload. ring_o is ring_i delayed by one clock. A non-idle flit whose target differs from NODE_ID leaves unchanged.
- R3: A request whose target is NODE_ID, arriving while the input buffer holds fewer than RX_DEPTH (2) packets, is stored. One clock later ring_o carries a positive echo with target set to the request's source, source set to NODE_ID, the same tag and payload 0.
- R4: Such a request arriving while the buffer is full is not stored. ring_o carries a negative echo with the same fields as in R3.
- R5: The input buffer presents stored packets in arrival order on rx_src_o/rx_payload_o with rx_valid_o. A packet is removed in a cycle where rx_valid_o and rx_ready_i are both high.
- R6: A local packet is accepted when tx_valid_i and tx_ready_o are both high. It goes into the lowest free slot, and its tag is that slot's index. It is sent as a request with source NODE_ID, never in the clock in which it is accepted.
- R7: A local packet is sent only in place of an incoming flit that is idle or is an echo addressed to this node. A non-idle incoming flit that is passed on or answered blocks injection. Waiting packets are sent lowest tag first.
- R8: tx_ready_o is 0 while all four slots hold packets. An echo addressed to this node is removed from the ring. If it is positive, it frees the slot with the matching tag, which can then be reused.
- R9: A negative echo addressed to this node causes the matching slot's packet to be sent again with unchanged target, tag and payload.
- R10: err_o becomes 1 when one slot has received RETRY_LIMIT (16) negative echoes. It stays 1 until reset, including after that slot is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ring_i | input | 18 | Flit arriving from the upstream neighbour |
| ring_o | output | 18 | Flit sent to the downstream neighbour |
| tx_valid_i | input | 1 | Local packet offered |
| tx_ready_o | output | 1 | A free outstanding slot exists |
| tx_target_i | input | 4 | Destination node of the local packet |
| tx_payload_i | input | 6 | Payload of the local packet |
| rx_valid_o | output | 1 | Input buffer holds a packet |
| rx_ready_i | input | 1 | Consumer takes the head packet |
| rx_src_o | output | 4 | Source node of the head packet |
| rx_payload_o | output | 6 | Payload of the head packet |
| err_o | output | 1 | Sticky retry-limit error |

## Verification
A slot state that is wrong shows up at the ports within a few clocks. A slot that is wrongly freed makes tx_ready_o rise early or lets a tag be reused while still in flight. A slot that is wrongly held blocks tx_ready_o after all echoes have returned. A lost retry mark shows as a missing resend on the clock after the slot next becomes empty. An input buffer count that is wrong shows in the very next outgoing flit, as an echo of the wrong polarity, and later as a missing or extra packet at the receive handshake. The retry counter is exercised up to the limit and one step short of it, so an off-by-one shows on err_o.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int FLIT_W = 18;
  localparam int ID_W   = 4;
  localparam int TAG_W  = 2;
  localparam int PL_W   = FLIT_W - 2 - 2*ID_W - TAG_W;
  localparam int SLOTS  = 1 << TAG_W;

  typedef enum logic [1:0] {
    K_IDLE = 2'b00,
    K_REQ  = 2'b01,
    K_POS  = 2'b10,
    K_NEG  = 2'b11
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [ID_W-1:0]   tgt;
    logic [ID_W-1:0]   src;
    logic [TAG_W-1:0]  tag;
    logic [PL_W-1:0]   pl;
  } flit_t;

  typedef enum logic [1:0] {
    S_FREE,
    S_PEND,
    S_WAIT
  } slot_e;
endpackage

// File: rtl/ring_rx_fifo.sv
module ring_rx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         pop_i,
  output logic [W-1:0] dout_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign dout_o  = mem_q[rd_q];
  assign do_pop  = pop_i && valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R4
endmodule

// File: rtl/ring_tx_slots.sv
module ring_tx_slots
  import ring_pkg::*;
#(
  parameter logic [ID_W-1:0] NODE_ID     = 4'd3,
  parameter int              RETRY_LIMIT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_valid_i,
  output logic             acc_ready_o,
  input  logic [ID_W-1:0]  acc_tgt_i,
  input  logic [PL_W-1:0]  acc_pl_i,
  input  logic             echo_vld_i,
  input  logic             echo_neg_i,
  input  logic [TAG_W-1:0] echo_tag_i,
  input  logic             inj_en_i,
  output logic             inj_vld_o,
  output flit_t            inj_flit_o,
  output logic             err_o
);
  localparam int CW = $clog2(RETRY_LIMIT + 1);

  slot_e           st_q  [SLOTS];
  logic [ID_W-1:0] tgt_q [SLOTS];
  logic [PL_W-1:0] pl_q  [SLOTS];
  logic [CW-1:0]   cnt_q [SLOTS];
  logic            err_q;

  logic [TAG_W-1:0] free_idx, pend_idx;
  logic             any_free, any_pend;

  always_comb begin
    free_idx = '0;
    pend_idx = '0;
    any_free = 1'b0;
    any_pend = 1'b0;
    for (int i = SLOTS-1; i >= 0; i--) begin
      if (st_q[i] == S_FREE) begin free_idx = TAG_W'(i); any_free = 1'b1; end
      if (st_q[i] == S_PEND) begin pend_idx = TAG_W'(i); any_pend = 1'b1; end
    end
  end

  assign acc_ready_o = any_free;
  assign inj_vld_o   = any_pend;
  assign err_o       = err_q;

  always_comb begin
    inj_flit_o.kind = K_REQ;
    inj_flit_o.tgt  = tgt_q[pend_idx];
    inj_flit_o.src  = NODE_ID;
    inj_flit_o.tag  = pend_idx;
    inj_flit_o.pl   = pl_q[pend_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        st_q[i]  <= S_FREE;
        tgt_q[i] <= '0;
        pl_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      if (acc_valid_i && any_free) begin
        st_q[free_idx]  <= S_PEND;
        tgt_q[free_idx] <= acc_tgt_i;
        pl_q[free_idx]  <= acc_pl_i;
      end
      if (inj_en_i && any_pend) st_q[pend_idx] <= S_WAIT;
      // echo to a slot not awaiting one is dropped
      if (echo_vld_i && st_q[echo_tag_i] == S_WAIT) begin
        if (echo_neg_i) begin
          st_q[echo_tag_i] <= S_PEND;
          if (cnt_q[echo_tag_i] != CW'(RETRY_LIMIT))
            cnt_q[echo_tag_i] <= cnt_q[echo_tag_i] + 1'b1;
          if (cnt_q[echo_tag_i] == CW'(RETRY_LIMIT-1)) err_q <= 1'b1;
        end else begin
          st_q[echo_tag_i]  <= S_FREE;
          cnt_q[echo_tag_i] <= '0;
        end
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_q) |-> err_q); // R10
  AST_ACCEPT_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_ready_o) |=> $countones({st_q[0] != S_FREE, st_q[1] != S_FREE,
      st_q[2] != S_FREE, st_q[3] != S_FREE}) != 0); // R8
endmodule

// File: rtl/ring_echo_node.sv
module ring_echo_node
  import ring_pkg::*;
#(
  parameter logic [3:0] NODE_ID     = 4'd3,
  parameter int          RX_DEPTH    = 2,
  parameter int          RETRY_LIMIT = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [17:0] ring_i,
  output logic [17:0] ring_o,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  input  logic [3:0]  tx_target_i,
  input  logic [5:0]  tx_payload_i,
  output logic        rx_valid_o,
  input  logic        rx_ready_i,
  output logic [3:0]  rx_src_o,
  output logic [5:0]  rx_payload_o,
  output logic        err_o
);
  localparam int RXW = ID_W + PL_W;

  flit_t in_f, nxt_f, inj_f, out_q;
  logic  for_us, req_us, echo_us, rx_full, accept, slot_empty, inj_vld;
  logic [RXW-1:0] rx_dout;

  assign in_f       = flit_t'(ring_i);
  assign for_us     = (in_f.kind != K_IDLE) && (in_f.tgt == NODE_ID);
  assign req_us     = for_us && (in_f.kind == K_REQ);
  assign echo_us    = for_us && (in_f.kind == K_POS || in_f.kind == K_NEG);
  assign accept     = req_us && !rx_full;
  assign slot_empty = (in_f.kind == K_IDLE) || echo_us;

  ring_rx_fifo #(.W(RXW), .DEPTH(RX_DEPTH)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .din_i   ({in_f.src, in_f.pl}),
    .full_o  (rx_full),
    .valid_o (rx_valid_o),
    .pop_i   (rx_ready_i),
    .dout_o  (rx_dout)
  );
  assign {rx_src_o, rx_payload_o} = rx_dout;

  ring_tx_slots #(.NODE_ID(NODE_ID), .RETRY_LIMIT(RETRY_LIMIT)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (tx_valid_i),
    .acc_ready_o (tx_ready_o),
    .acc_tgt_i   (tx_target_i),
    .acc_pl_i    (tx_payload_i),
    .echo_vld_i  (echo_us),
    .echo_neg_i  (in_f.kind == K_NEG),
    .echo_tag_i  (in_f.tag),
    .inj_en_i    (slot_empty),
    .inj_vld_o   (inj_vld),
    .inj_flit_o  (inj_f),
    .err_o       (err_o)
  );

  always_comb begin
    nxt_f = in_f;
    if (req_us) begin
      nxt_f.kind = accept ? K_POS : K_NEG;
      nxt_f.tgt  = in_f.src;
      nxt_f.src  = NODE_ID;
      nxt_f.pl   = '0;
    end else if (echo_us) begin
      nxt_f = '0;
    end
    if (slot_empty && inj_vld) nxt_f = inj_f;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= nxt_f;
  end
  assign ring_o = out_q;

  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_i[17:16] != 2'b00 && ring_i[15:12] != NODE_ID) |=> ring_o == $past(ring_i)); // R2
  AST_ECHO_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_o[17] && ring_o[11:8] == NODE_ID)
      |-> ($past(ring_i[17:16]) == 2'b01 && $past(ring_i[15:12]) == NODE_ID)); // R3
  AST_INJECT_EMPTY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_o[17:16] == 2'b01 && ring_o[11:8] == NODE_ID)
      |-> ($past(ring_i[17:16]) == 2'b00 ||
           ($past(ring_i[17]) && $past(ring_i[15:12]) == NODE_ID))); // R7
endmodule

// File: tb/tb_ring_echo_node.sv
`timescale 1ns/1ps
module tb_ring_echo_node;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [17:0] ring_i = '0, ring_o;
  logic        tx_valid = 1'b0, tx_ready;
  logic [3:0]  tx_target = '0;
  logic [5:0]  tx_payload = '0;
  logic        rx_valid, rx_ready = 1'b0;
  logic [3:0]  rx_src;
  logic [5:0]  rx_payload;
  logic        err;

  int checks = 0, fails = 0;
  logic [17:0] exp_q[$];
  string       req_q[$];
  logic [9:0]  rx_q[$];

  always #2 clk = ~clk;

  ring_echo_node dut (
    .clk_i(clk), .rst_ni(rst_n), .ring_i(ring_i), .ring_o(ring_o),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_target_i(tx_target),
    .tx_payload_i(tx_payload), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_src_o(rx_src), .rx_payload_o(rx_payload), .err_o(err)
  );

  function automatic logic [17:0] mk(input logic [1:0] k, input logic [3:0] t,
                                     input logic [3:0] s, input logic [1:0] g,
                                     input logic [5:0] p);
    return {k, t, s, g, p};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [17:0] din, input logic [17:0] exp, input string req);
    @(negedge clk);
    ring_i = din;
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(posedge clk);
    #1;
  endtask

  // ring monitor
  initial forever begin
    @(posedge clk);
    #0.5;
    if (exp_q.size() > 0) begin
      logic [17:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(ring_o == e, r, 32'(ring_o), 32'(e));
    end
  end

  // receive monitor: R5
  initial forever begin
    @(negedge clk);
    #0.5;
    if (rx_valid && rx_ready) begin
      if (rx_q.size() == 0) chk(1'b0, "R5", {rx_src, rx_payload}, 0);
      else begin
        logic [9:0] e;
        e = rx_q.pop_front();
        chk({rx_src, rx_payload} == e, "R5", {rx_src, rx_payload}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [17:0] IDLE = 18'h0;

  initial begin
    logic [17:0] pt;
    pt = mk(2'b01, 4'd5, 4'd7, 2'd2, 6'h0C);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1
    chk(ring_o == IDLE, "R1", ring_o, 0);
    chk(tx_ready == 1'b1, "R1", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1", rx_valid, 0);
    chk(err == 1'b0, "R1", err, 0);

    // R2 pass-through of request and foreign echo
    step(pt, pt, "R2");
    step(mk(2'b10, 4'd6, 4'd5, 2'd1, 6'h0), mk(2'b10, 4'd6, 4'd5, 2'd1, 6'h0), "R2");
    step(IDLE, IDLE, "R2");

    // R3 / R4 receive with buffer filling
    step(mk(2'b01, 4'd3, 4'd5, 2'd1, 6'h2A), mk(2'b10, 4'd5, 4'd3, 2'd1, 6'h0), "R3");
    rx_q.push_back({4'd5, 6'h2A});
    step(mk(2'b01, 4'd3, 4'd6, 2'd2, 6'h11), mk(2'b10, 4'd6, 4'd3, 2'd2, 6'h0), "R3");
    rx_q.push_back({4'd6, 6'h11});
    step(mk(2'b01, 4'd3, 4'd7, 2'd3, 6'h3F), mk(2'b11, 4'd7, 4'd3, 2'd3, 6'h0), "R4");
    chk(rx_valid == 1'b1, "R5", rx_valid, 1);
    rx_ready = 1'b1;
    step(IDLE, IDLE, "R5");
    step(IDLE, IDLE, "R5");
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R4", rx_valid, 0);
    chk(rx_q.size() == 0, "R5", rx_q.size(), 0);

    // R6 basic send and positive echo
    tx_valid = 1'b1; tx_target = 4'd9; tx_payload = 6'h15;
    step(IDLE, IDLE, "R6");
    tx_valid = 1'b0;
    step(IDLE, mk(2'b01, 4'd9, 4'd3, 2'd0, 6'h15), "R6");
    step(mk(2'b10, 4'd3, 4'd9, 2'd0, 6'h0), IDLE, "R8");

    // R7 busy ring defers injection
    tx_valid = 1'b1; tx_target = 4'd10; tx_payload = 6'h05;
    step(IDLE, IDLE, "R6");
    tx_valid = 1'b0;
    step(pt, pt, "R7");
    step(mk(2'b10, 4'd6, 4'd5, 2'd1, 6'h0), mk(2'b10, 4'd6, 4'd5, 2'd1, 6'h0), "R7");
    step(IDLE, mk(2'b01, 4'd10, 4'd3, 2'd0, 6'h05), "R7");
    // R9 negative echo triggers resend
    step(mk(2'b11, 4'd3, 4'd10, 2'd0, 6'h0), IDLE, "R9");
    step(IDLE, mk(2'b01, 4'd10, 4'd3, 2'd0, 6'h05), "R9");
    step(mk(2'b10, 4'd3, 4'd10, 2'd0, 6'h0), IDLE, "R8");

    // R8 fill all slots under through traffic
    for (int i = 0; i < 4; i++) begin
      tx_valid = 1'b1; tx_target = 4'(4 + i); tx_payload = 6'(6'h20 + i);
      step(pt, pt, "R7");
    end
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R8", tx_ready, 0);
    for (int i = 0; i < 4; i++)
      step(IDLE, mk(2'b01, 4'(4 + i), 4'd3, 2'(i), 6'(6'h20 + i)), "R7");
    step(mk(2'b10, 4'd3, 4'd6, 2'd2, 6'h0), IDLE, "R8");
    chk(tx_ready == 1'b1, "R8", tx_ready, 1);
    tx_valid = 1'b1; tx_target = 4'd12; tx_payload = 6'h33;
    step(IDLE, IDLE, "R6");
    tx_valid = 1'b0;
    step(IDLE, mk(2'b01, 4'd12, 4'd3, 2'd2, 6'h33), "R6");
    step(mk(2'b10, 4'd3, 4'd4, 2'd0, 6'h0), IDLE, "R8");
    step(mk(2'b10, 4'd3, 4'd5, 2'd1, 6'h0), IDLE, "R8");
    step(mk(2'b10, 4'd3, 4'd7, 2'd3, 6'h0), IDLE, "R8");
    step(mk(2'b10, 4'd3, 4'd12, 2'd2, 6'h0), IDLE, "R8");
    chk(tx_ready == 1'b1, "R8", tx_ready, 1);

    // R10 retry limit
    tx_valid = 1'b1; tx_target = 4'd8; tx_payload = 6'h2B;
    step(IDLE, IDLE, "R6");
    tx_valid = 1'b0;
    step(IDLE, mk(2'b01, 4'd8, 4'd3, 2'd0, 6'h2B), "R6");
    for (int i = 1; i <= 16; i++) begin
      step(mk(2'b11, 4'd3, 4'd8, 2'd0, 6'h0), IDLE, "R9");
      if (i == 15) chk(err == 1'b0, "R10", err, 0);
      step(IDLE, mk(2'b01, 4'd8, 4'd3, 2'd0, 6'h2B), "R9");
    end
    chk(err == 1'b1, "R10", err, 1);
    step(mk(2'b10, 4'd3, 4'd8, 2'd0, 6'h0), IDLE, "R8");
    step(IDLE, IDLE, "R2");
    chk(err == 1'b1, "R10", err, 1);

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule